// File: doc/BRIEF.md
# Timed Lock and Fuse Access Unit

This unit sits beside a small processor core and guards its protection byte and two configuration bytes. Software reaches them through a control register and a short arming window. Writing the arming value to the control register opens a window of a few clock cycles, counted in hardware. Within that window, the next store-program strobe programs the boot-protection bits from a data operand. A load-program-memory strobe instead returns one of the protected bytes, chosen by the 16-bit Z pointer, on the destination bus in the same cycle.

Outside a window every load strobe passes the flash read data through unchanged. An EEPROM-busy input refuses control writes and protected accesses. The unit also holds a model of one-way protection storage. Programming can only clear bits, and a separate erase input restores them to the erased state. The two configuration bytes are fixed by parameters.

Top module: `prot_access_unit`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00 and `dest_data` equals `flash_rdata`. The boot-protection bits read 1111 and the two low protection bits equal the `LB_INIT` parameter.
- R2: When `ee_busy` is low, a `ctl_wr` pulse stores `ctl_wdata[6:0]`, and `ctl_rdata` shows `{1'b0, stored[6:0]}` from the next cycle. Bit 7 always reads 0.
- R3: The window opens only when the stored value has bits 6..0 equal to 0001001 (bit 3 lock-select and bit 0 enable set, all other bits clear). Any other stored value leaves both strobes behaving as ordinary accesses.
- R4: Cycle k after an arming write is the k-th cycle after the writing clock edge. A store strobe in cycle k with k from 1 to 4 performs boot-bits = boot-bits AND `wr_operand[5:2]`. A cleared operand bit programs that bit, and `zptr` is ignored.
- R5: A load strobe in cycle k with k from 1 to 3 drives the selected byte on `dest_data` in that same cycle. Z=0x0000 selects the low configuration byte and Z=0x0003 the high one. Z=0x0001 selects the protection byte laid out as {1,1,boot[3:0],low[1:0]}. Any other Z returns 0xFF.
- R6: A load strobe that is not inside a load window outputs `flash_rdata` unchanged. A store strobe outside a store window leaves the bits unchanged.
- R7: After an arming write, `ctl_rdata` bits 3 and 0 auto-clear in the cycle after the first protected access. If no protected access occurs, they clear after cycle 4, so `ctl_rdata` reads 0x00 from cycle 5.
- R8: Protection bits are one-way. A store never changes a 0 bit back to 1.
- R9: A pulse on `erase_all` sets all six protection bits to 1 from the next cycle.
- R10: While `ee_busy` is high, `ctl_wr` is ignored. Strobes then act as ordinary accesses and do not consume the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| ee_busy | input | 1 | EEPROM write in progress |
| spm_stb | input | 1 | Decoded store-program strobe |
| lpm_stb | input | 1 | Decoded load-program-memory strobe |
| zptr | input | 16 | Z pointer operand |
| wr_operand | input | 8 | Data operand of the store |
| flash_rdata | input | 8 | Ordinary program memory read data |
| dest_data | output | 8 | Destination register data for loads |
| erase_all | input | 1 | Restore all protection bits to 1 |

## Verification
The assertions assume that the decoder never raises the store and load strobes in the same cycle; one property checks this input rule directly. The one-way property also takes for granted that `erase_all` is the only way bits can return to 1. The stimulus issues at most one strobe per cycle and pulses erase only between access sequences. It holds `ee_busy` only across chosen write or access cycles, so the busy rules are exercised without ever overlapping both strobes.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam logic [6:0]  ARM_PATTERN = 7'b0001001;
    localparam int          CTL_LOCKSEL = 3;
    localparam int          CTL_ENABLE  = 0;
    localparam logic [15:0] Z_CFG_LO    = 16'h0000;
    localparam logic [15:0] Z_PROT      = 16'h0001;
    localparam logic [15:0] Z_CFG_HI    = 16'h0003;
    localparam logic [7:0]  UNMAPPED    = 8'hFF;

    typedef struct packed {
        logic [3:0] boot;
        logic [1:0] low;
    } prot_bits_t;

    function automatic logic [7:0] pack_prot(prot_bits_t p);
        return {2'b11, p.boot, p.low};
    endfunction
endpackage

// File: rtl/prot_arm_window.sv
module prot_arm_window #(
    parameter int WIN_STORE = 4,
    parameter int WIN_LOAD  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       ee_busy,
    input  logic       spm_stb,
    input  logic       lpm_stb,
    output logic [6:0] ctl_val,
    output logic       lock_wr,
    output logic       prot_rd
);
    import prot_pkg::*;

    localparam int AW = $clog2(WIN_STORE + 1);
    localparam logic [AW-1:0] ST_LIM = AW'(WIN_STORE);
    localparam logic [AW-1:0] LD_LIM = AW'(WIN_LOAD);

    typedef struct packed {
        logic [6:0]    ctl;
        logic [AW-1:0] age;
    } win_t;

    win_t s_d, s_q;
    logic armed, in_store, in_load, spm_ok, lpm_ok;

    always_comb begin
        armed    = (s_q.ctl == ARM_PATTERN) && (s_q.age != '0);
        in_store = armed && (s_q.age <= ST_LIM);
        in_load  = armed && (s_q.age <= LD_LIM);
        spm_ok   = in_store && spm_stb && !ee_busy;
        lpm_ok   = in_load && lpm_stb && !ee_busy && !spm_stb;

        s_d = s_q;
        if (armed) begin
            if (spm_ok || lpm_ok || (s_q.age >= ST_LIM)) begin
                s_d.ctl[CTL_LOCKSEL] = 1'b0;
                s_d.ctl[CTL_ENABLE]  = 1'b0;
                s_d.age              = '0;
            end else begin
                s_d.age = s_q.age + 1'b1;
            end
        end
        if (ctl_wr && !ee_busy) begin
            s_d.ctl = ctl_wdata[6:0];
            s_d.age = AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_val = s_q.ctl;
    assign lock_wr = spm_ok;
    assign prot_rd = lpm_ok;
endmodule

// File: rtl/prot_nv_store.sv
module prot_nv_store #(
    parameter logic [1:0] LB_INIT = 2'b11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_wr,
    input  logic [7:0]           wr_operand,
    input  logic                 erase_all,
    output prot_pkg::prot_bits_t bits
);
    import prot_pkg::*;

    prot_bits_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (erase_all) begin
            b_d.boot = 4'hF;
            b_d.low  = 2'b11;
        end else if (lock_wr) begin
            b_d.boot = b_q.boot & wr_operand[5:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.boot <= 4'hF;
            b_q.low  <= LB_INIT;
        end else begin
            b_q <= b_d;
        end
    end

    assign bits = b_q;
endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux #(
    parameter logic [7:0] CFG_LO = 8'hE1,
    parameter logic [7:0] CFG_HI = 8'hD9
) (
    input  logic                 prot_rd,
    input  logic [15:0]          zptr,
    input  prot_pkg::prot_bits_t bits,
    input  logic [7:0]           flash_rdata,
    output logic [7:0]           dest_data
);
    import prot_pkg::*;

    logic [7:0] sel;

    always_comb begin
        unique case (zptr)
            Z_CFG_LO: sel = CFG_LO;
            Z_PROT:   sel = pack_prot(bits);
            Z_CFG_HI: sel = CFG_HI;
            default:  sel = UNMAPPED;
        endcase
        dest_data = prot_rd ? sel : flash_rdata;
    end
endmodule

// File: rtl/prot_access_unit.sv
module prot_access_unit #(
    parameter int         WIN_STORE = 4,
    parameter int         WIN_LOAD  = 3,
    parameter logic [7:0] CFG_LO    = 8'hE1,
    parameter logic [7:0] CFG_HI    = 8'hD9,
    parameter logic [1:0] LB_INIT   = 2'b10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic        ee_busy,
    input  logic        spm_stb,
    input  logic        lpm_stb,
    input  logic [15:0] zptr,
    input  logic [7:0]  wr_operand,
    input  logic [7:0]  flash_rdata,
    output logic [7:0]  dest_data,
    input  logic        erase_all
);
    import prot_pkg::*;

    logic [6:0] ctl_val;
    logic       lock_wr, prot_rd;
    prot_bits_t bits;

    prot_arm_window #(.WIN_STORE(WIN_STORE), .WIN_LOAD(WIN_LOAD)) u_win (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ee_busy(ee_busy), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
        .ctl_val(ctl_val), .lock_wr(lock_wr), .prot_rd(prot_rd)
    );

    prot_nv_store #(.LB_INIT(LB_INIT)) u_store (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .wr_operand(wr_operand),
        .erase_all(erase_all), .bits(bits)
    );

    prot_read_mux #(.CFG_LO(CFG_LO), .CFG_HI(CFG_HI)) u_mux (
        .prot_rd(prot_rd), .zptr(zptr), .bits(bits),
        .flash_rdata(flash_rdata), .dest_data(dest_data)
    );

    assign ctl_rdata = {1'b0, ctl_val};
endmodule

// File: rtl/prot_access_chk.sv
module prot_access_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_rdata,
    input logic       ee_busy,
    input logic       spm_stb,
    input logic       lpm_stb,
    input logic [7:0] flash_rdata,
    input logic [7:0] dest_data,
    input logic       erase_all,
    input logic       lock_wr,
    input logic       prot_rd,
    input logic [5:0] bits
);
    // R8
    one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_all |=> ((bits & ~$past(bits)) == 6'd0));

    // R10
    busy_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |-> (!lock_wr && !prot_rd));

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && ctl_wr && !ctl_rdata[3] && !ctl_rdata[0]) |=> $stable(ctl_rdata));

    // R6
    plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_stb && !prot_rd) |-> (dest_data == flash_rdata));

    // R7
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_wr || prot_rd) && !ctl_wr) |=> (!ctl_rdata[3] && !ctl_rdata[0]));

    // R4
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spm_stb && lpm_stb));

    // R2
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7] == 1'b0);
endmodule

bind prot_access_unit prot_access_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
    .ee_busy(ee_busy), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
    .flash_rdata(flash_rdata), .dest_data(dest_data), .erase_all(erase_all),
    .lock_wr(lock_wr), .prot_rd(prot_rd), .bits(bits)
);

// File: tb/sim_prot_access_unit.sv
module sim_prot_access_unit;
    localparam logic [7:0] CLO = 8'hE1;
    localparam logic [7:0] CHI = 8'hD9;
    localparam logic [1:0] LBI = 2'b10;

    logic clk = 0, rst_n = 0;
    logic ctl_wr = 0, ee_busy = 0, spm_stb = 0, lpm_stb = 0, erase_all = 0;
    logic [7:0] ctl_wdata = 0, wr_operand = 0, flash_rdata = 0;
    logic [15:0] zptr = 0;
    logic [7:0] ctl_rdata, dest_data;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [3:0] m_boot = 4'hF;
    logic [1:0] m_low = LBI;
    logic [6:0] m_ctl = 7'd0;

    always #5 clk = ~clk;

    prot_access_unit #(.WIN_STORE(4), .WIN_LOAD(3), .CFG_LO(CLO), .CFG_HI(CHI),
                       .LB_INIT(LBI)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ee_busy(ee_busy), .spm_stb(spm_stb),
        .lpm_stb(lpm_stb), .zptr(zptr), .wr_operand(wr_operand),
        .flash_rdata(flash_rdata), .dest_data(dest_data), .erase_all(erase_all)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sel(input logic [15:0] z);
        case (z)
            16'h0000: return CLO;
            16'h0001: return {2'b11, m_boot, m_low};
            16'h0003: return CHI;
            default:  return 8'hFF;
        endcase
    endfunction

    task automatic idle();
        ctl_wr = 0; spm_stb = 0; lpm_stb = 0; erase_all = 0; ee_busy = 0;
    endtask

    // one write, then an access strobe in cycle d (op: 0 store, 1 load)
    task automatic run_case(input logic [7:0] wv, input int d, input bit op,
                            input logic [15:0] z, input logic [7:0] r0,
                            input bit busy_wr);
        bit pat;
        logic [7:0] fl, exp;
        @(negedge clk);
        idle();
        ctl_wr = 1; ctl_wdata = wv; ee_busy = busy_wr;
        pat = !busy_wr && (wv[6:0] == 7'b0001001);
        if (!busy_wr) m_ctl = wv[6:0];
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            idle();
            if (k == d) begin
                // R2 R3 R7 R10 readback before the access
                exp = (pat && k > 4) ? 8'h00 : {1'b0, m_ctl};
                chk(ctl_rdata == exp, "R2/R7/R10 readback", ctl_rdata, exp);
                fl = 8'($urandom);
                flash_rdata = fl; zptr = z; wr_operand = r0;
                if (op) lpm_stb = 1; else spm_stb = 1;
                #1;
                if (op) begin
                    exp = (pat && d <= 3) ? exp_sel(z) : fl;
                    chk(dest_data == exp, (pat && d <= 3) ? "R5 protected load" :
                        "R6 R3 plain load", dest_data, exp);
                end else if (pat && d <= 4) begin
                    m_boot = m_boot & r0[5:2];
                end
            end
        end
        @(negedge clk);
        idle();
        if (pat) m_ctl = 7'd0;
        chk(ctl_rdata == {1'b0, m_ctl}, "R7 auto-clear", ctl_rdata, {1'b0, m_ctl});
    endtask

    task automatic read_prot(input string req);
        logic [7:0] e;
        @(negedge clk); idle(); ctl_wr = 1; ctl_wdata = 8'h09;
        @(negedge clk); idle(); lpm_stb = 1; zptr = 16'h0001; #1;
        e = {2'b11, m_boot, m_low};
        chk(dest_data == e, req, dest_data, e);
        @(negedge clk); idle();
        m_ctl = 7'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        flash_rdata = 8'h5A;
        #1;
        // R1 reset state
        chk(ctl_rdata == 8'h00, "R1 reset ctl", ctl_rdata, 8'h00);
        chk(dest_data == 8'h5A, "R1 reset dest", dest_data, 8'h5A);
        rst_n = 1;
        read_prot("R1 reset protection byte");

        // directed: each Z at the edge of the load window
        run_case(8'h09, 3, 1, 16'h0000, 8'hFF, 0);   // R5 cfg low
        run_case(8'h89, 1, 1, 16'h0003, 8'hFF, 0);   // R5 cfg high, R2 bit7
        run_case(8'h09, 2, 1, 16'h0002, 8'hFF, 0);   // R5 unmapped
        run_case(8'h09, 4, 1, 16'h0001, 8'hFF, 0);   // R6 load past window
        run_case(8'h0B, 1, 1, 16'h0001, 8'hFF, 0);   // R3 wrong pattern
        run_case(8'h08, 1, 0, 16'h0000, 8'h00, 0);   // R3 store not armed
        read_prot("R3 no program when unarmed");
        run_case(8'h09, 5, 0, 16'h1234, 8'h00, 0);   // R6 store past window
        read_prot("R6 no program late");
        run_case(8'h09, 4, 0, 16'h1234, 8'hFB, 0);   // R4 last store cycle
        read_prot("R4 program boot bit");
        run_case(8'h09, 1, 0, 16'h0000, 8'hFF, 0);   // R8 ones do not restore
        read_prot("R8 one-way");
        run_case(8'h09, 1, 1, 16'h0001, 8'hFF, 1);   // R10 busy write
        // R10 busy access does not consume
        @(negedge clk); idle(); ctl_wr = 1; ctl_wdata = 8'h09;
        @(negedge clk); idle(); ee_busy = 1; lpm_stb = 1; zptr = 16'h0003;
        flash_rdata = 8'h33; #1;
        chk(dest_data == 8'h33, "R10 busy load plain", dest_data, 8'h33);
        @(negedge clk); idle(); lpm_stb = 1; zptr = 16'h0003; #1;
        chk(dest_data == CHI, "R10 window kept", dest_data, CHI);
        @(negedge clk); idle(); m_ctl = 7'd0;
        // R9 erase
        @(negedge clk); idle(); erase_all = 1;
        @(negedge clk); idle(); m_boot = 4'hF; m_low = 2'b11;
        read_prot("R9 erase");

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [7:0] wv;
            logic [15:0] z;
            wv = ($urandom_range(0, 3) != 0) ? {1'($urandom), 7'b0001001} : 8'($urandom);
            case ($urandom_range(0, 4))
                0: z = 16'h0000;
                1: z = 16'h0001;
                2: z = 16'h0003;
                default: z = 16'($urandom);
            endcase
            run_case(wv, $urandom_range(1, 6), 1'($urandom), z,
                     8'($urandom) | 8'($urandom) | 8'($urandom),
                     $urandom_range(0, 9) == 0);
            if (n % 40 == 39) begin
                @(negedge clk); idle(); erase_all = 1;
                @(negedge clk); idle(); m_boot = 4'hF; m_low = 2'b11;
                read_prot("R9 erase random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule